// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked system to an external asynchronous static RAM that stores 2K words of one byte each. The system offers one read or write at a time on a simple request/ready handshake. The controller then produces the active-low chip-select, output-enable and write-enable strobes, the address and the outgoing byte for the memory. It also enables the driver of the bidirectional data lane and captures the returned byte.

Each timing limit of the memory is a parameter in nanoseconds. These limits are address setup, write pulse, data overlap, write recovery, write cycle, access time and read cycle. The controller turns each one into a whole number of system clock cycles by rounding up, and no phase is ever shorter than one cycle. Writes are strobed by write enable, and output enable stays high during them, so the plain write pulse limit applies. The address is registered when a request is accepted and does not change again until the controller has returned to idle.

A state machine steps through these states:
- Idle: IDLE.
- Write: W_SETUP (select, strobe high), then W_PULSE (strobe low), then W_HOLD (strobe high, data still driven), then W_REC (deselected).
- Read: R_ACCESS (select and output enable low), then R_REC (deselected).

The transitions are:
- IDLE to W_SETUP or R_ACCESS when a request arrives.
- Each later state moves to the next one when its phase counter expires.
- W_REC and R_REC return to IDLE.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, `ready` is 1, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `ready` are both 1. `ready` is 0 from that edge until the whole cycle ends. That is 6 cycles for a write and 4 cycles for a read at the default parameters (5 ns clock).
- R3: A write keeps `mem_cs_n` low with `mem_we_n` high for the setup phase (1 cycle). It then drives `mem_we_n` low for the pulse phase, which is the larger of the rounded pulse and data-overlap limits (3 cycles). Next comes 1 hold cycle with `mem_cs_n` still low and `mem_we_n` high. The write then deselects for the recovery phase (1 cycle), which is also stretched if needed to meet the write cycle limit.
- R4: `mem_oe_n` stays 1 during the whole of a write.
- R5: `mem_dq_oe` is 1 exactly while `mem_we_n` is low plus one cycle after it rises. While enabled, `mem_dq_out` equals the accepted write byte.
- R6: `mem_addr` equals the accepted address from acceptance to the end of the cycle, and it never changes while `mem_we_n` is low.
- R7: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for the access phase (3 cycles). It captures `mem_dq_in` into `rd_data` on the last edge of that phase, then deselects for the recovery phase (1 cycle). `rd_data` keeps its value until the next read completes.
- R8: `req_valid` asserted while `ready` is 0 is ignored: no second access is started and no memory location is touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to accept |
| rd_data | output | 8 | Byte captured by the last read |
| mem_addr | output | 11 | Memory address lines |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_oe | output | 1 | Enable for the controller's data-lane driver |
| mem_dq_out | output | 8 | Byte driven onto the data lane |
| mem_dq_in | input | 8 | Byte sampled from the data lane |

## Verification
The bench models the memory. Its byte only becomes valid once the access has lasted the rounded access time, so a controller that samples one edge early captures a filler byte rather than the stored one. The memory stores a filler byte if write enable is low while the controller's driver is off, so a driver that opens late, or closes before write enable rises, corrupts the location. A full write sweep followed by a read sweep of every address catches address bits that slip during the strobe or are latched at the wrong moment. Requests held high during a busy cycle target a different address with different data, so a controller that starts a second access leaves a visible overwrite.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_SETUP,
        ST_W_PULSE,
        ST_W_HOLD,
        ST_W_REC,
        ST_R_ACCESS,
        ST_R_REC
    } ctrl_state_e;

    // Round a time up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/sram_lane_regs.sv
module sram_lane_regs #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take_req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 5,
    parameter int T_AS_NS = 0,
    parameter int T_WP_NS = 12,
    parameter int T_DW_NS = 12,
    parameter int T_WR_NS = 0,
    parameter int T_WC_NS = 15,
    parameter int T_AA_NS = 15,
    parameter int T_RC_NS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Phase lengths in cycles
    localparam int SU_CYC  = ns_to_cycles(T_AS_NS, CLK_NS);
    localparam int WP_CYC  = max_int(ns_to_cycles(T_WP_NS, CLK_NS),
                                     ns_to_cycles(T_DW_NS, CLK_NS));
    localparam int HD_CYC  = 1;
    localparam int WC_CYC  = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int WR_CYC  = max_int(ns_to_cycles(T_WR_NS, CLK_NS),
                                     WC_CYC - SU_CYC - WP_CYC - HD_CYC);
    localparam int AA_CYC  = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int RR_CYC  = max_int(1, ns_to_cycles(T_RC_NS, CLK_NS) - AA_CYC);
    localparam int MAX_LEN = max_int(max_int(max_int(SU_CYC, WP_CYC), max_int(WR_CYC, AA_CYC)),
                                     max_int(RR_CYC, HD_CYC));
    localparam int CW      = $clog2(MAX_LEN + 1);

    ctrl_state_e   state, nxt;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          take_req;
    logic          capture;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and phase-counter loading
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take_req = 1'b0;
        capture  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        nxt     = ST_W_SETUP;
                        tmr_val = CW'(SU_CYC - 1);
                    end else begin
                        nxt     = ST_R_ACCESS;
                        tmr_val = CW'(AA_CYC - 1);
                    end
                end
            end
            ST_W_SETUP: if (tmr_done) begin
                nxt      = ST_W_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CW'(WP_CYC - 1);
            end
            ST_W_PULSE: if (tmr_done) begin
                nxt      = ST_W_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CW'(HD_CYC - 1);
            end
            ST_W_HOLD: if (tmr_done) begin
                nxt      = ST_W_REC;
                tmr_load = 1'b1;
                tmr_val  = CW'(WR_CYC - 1);
            end
            ST_W_REC: if (tmr_done) begin
                nxt = ST_IDLE;
            end
            ST_R_ACCESS: if (tmr_done) begin
                nxt      = ST_R_REC;
                capture  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CW'(RR_CYC - 1);
            end
            ST_R_REC: if (tmr_done) begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Memory strobes decoded from the state
    always_comb begin
        ready     = 1'b0;
        mem_cs_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state)
            ST_IDLE:     ready = 1'b1;
            ST_W_SETUP:  mem_cs_n = 1'b0;
            ST_W_PULSE: begin
                mem_cs_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_W_HOLD: begin
                mem_cs_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_W_REC:    ;
            ST_R_ACCESS: begin
                mem_cs_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_R_REC:    ;
            default:     ;
        endcase
    end

    sram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_req  (take_req),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rd_data)
    );

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [DATA_W-1:0] mem_dq_out
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !mem_we_n) |=> !ready);

    assert_strobe_in_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

    assert_drive_during_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    assert_drive_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    assert_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    assert_addr_steady_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

    assert_addr_steady_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> $stable(mem_addr));

    assert_read_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_dq_oe && !mem_cs_n));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_out (mem_dq_out)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    // Expected phase lengths at 5 ns clock: ceil(ns/5), min 1
    localparam int SU = 1;   // setup 0 ns -> 1
    localparam int WP = 3;   // max(12,12) ns -> 3
    localparam int HD = 1;
    localparam int WR = 1;   // max(1, 3-5)
    localparam int AA = 3;   // 15 ns -> 3
    localparam int RR = 1;   // max(1, 3-3)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in;

    int n_checks = 0;
    int n_fail = 0;

    logic [DW-1:0] mem [DEPTH];
    int rd_age = 0;

    always #2.5 clk = ~clk;

    sram_async_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in)
    );

    // Memory model: writes while selected and strobed; read data valid after AA cycles
    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n)
            mem[mem_addr] = mem_dq_oe ? mem_dq_out : 8'hA5;
        if (!mem_cs_n && !mem_oe_n && mem_we_n)
            rd_age = rd_age + 1;
        else
            rd_age = 0;
    end
    assign mem_dq_in = (rd_age >= AA) ? mem[mem_addr] : 8'hEE;

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 37 + (a >> 8) + 11);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input bit spam);
        int busy = 0;
        int seq_bad = 0;
        int oe_bad = 0;
        int drv_bad = 0;
        int adr_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        if (spam) begin
            req_addr = AW'(a) ^ {AW{1'b1}}; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 1; i < 40; i++) begin
            if (ready) break;
            busy++;
            if (mem_cs_n != (i > SU + WP + HD)) seq_bad++;
            if (mem_we_n != !(i > SU && i <= SU + WP)) seq_bad++;
            if (!mem_oe_n) oe_bad++;
            if (mem_dq_oe != (i > SU && i <= SU + WP + HD)) drv_bad++;
            if (mem_dq_oe && mem_dq_out != d) drv_bad++;
            if (mem_addr != AW'(a)) adr_bad++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(busy == SU + WP + HD + WR, "R2", "write busy cycles", busy, SU + WP + HD + WR);
        chk(seq_bad == 0, "R3", "write strobe sequence errors", seq_bad, 0);
        chk(oe_bad == 0, "R4", "oe low during write", oe_bad, 0);
        chk(drv_bad == 0, "R5", "driver window/data errors", drv_bad, 0);
        chk(adr_bad == 0, "R6", "address errors in write", adr_bad, 0);
    endtask

    task automatic do_read(input int a, input logic [DW-1:0] exp, input bit spam);
        int busy = 0;
        int seq_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        if (spam) begin
            req_write = 1'b1; req_addr = AW'(a) ^ {AW{1'b1}}; req_wdata = 8'h3C;
        end else begin
            req_valid = 1'b0;
        end
        for (int i = 1; i < 40; i++) begin
            if (ready) break;
            busy++;
            if (mem_cs_n != (i > AA)) seq_bad++;
            if (mem_oe_n != (i > AA)) seq_bad++;
            if (!mem_we_n || mem_dq_oe) seq_bad++;
            if (mem_addr != AW'(a)) seq_bad++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(busy == AA + RR, "R2", "read busy cycles", busy, AA + RR);
        chk(seq_bad == 0, "R7", "read strobe sequence errors", seq_bad, 0);
        chk(rd_data == exp, "R7", "read data", rd_data, exp);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "reset outputs",
            {ready, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "idle outputs",
            {ready, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);

        // Full sweep: write every address, then read every address
        for (int a = 0; a < DEPTH; a++) do_write(a, pat(a), 1'b0);
        @(negedge clk);
        chk(ready && mem_cs_n && mem_we_n && !mem_dq_oe, "R1", "idle after writes",
            {ready, mem_cs_n, mem_we_n, mem_dq_oe}, 4'b1110);
        for (int a = 0; a < DEPTH; a++) do_read(a, pat(a), 1'b0);

        // Overwrite a few locations, check neighbours and rd_data retention
        do_write(5, 8'hFF, 1'b0);
        do_write(6, 8'h00, 1'b0);
        chk(rd_data == pat(DEPTH - 1), "R7", "rd_data kept across writes", rd_data, pat(DEPTH - 1));
        do_read(5, 8'hFF, 1'b0);
        do_read(6, 8'h00, 1'b0);
        do_read(7, pat(7), 1'b0);

        // R8: requests held during busy cycles are ignored
        do_write(100, 8'h96, 1'b1);
        do_read(100, 8'h96, 1'b0);
        do_read(100 ^ (DEPTH - 1), pat(100 ^ (DEPTH - 1)), 1'b0);
        chk(mem[100 ^ (DEPTH - 1)] == pat(100 ^ (DEPTH - 1)), "R8", "spam write target untouched",
            mem[100 ^ (DEPTH - 1)], pat(100 ^ (DEPTH - 1)));
        do_read(200, pat(200), 1'b1);
        do_read(200 ^ (DEPTH - 1), pat(200 ^ (DEPTH - 1)), 1'b0);
        @(negedge clk);
        chk(ready && mem_cs_n, "R8", "idle after ignored request", {ready, mem_cs_n}, 2'b11);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule